// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the eight pins of a general-purpose I/O port and decides, pin by pin, when an interrupt event has happened. The pin synchroniser and the port data register sit outside it. They deliver the present pin values, the values from one cycle earlier and the per-pin direction. From these and four small configuration registers the block keeps a sticky raw event vector. It derives a masked copy of that vector and drives one combined interrupt line.

Each pin can be set up on its own. It can be level-sensed or edge-sensed. An edge-sensed pin can react to one edge or to both edges, and a polarity bit picks the high level or rising edge, or the low level or falling edge. Software reads the raw and masked vectors and clears events by writing ones to a clear location. All of this goes through a simple word-addressed register port that this block decodes.

Top module: `gpio_irq_detect`

## Requirements
- R1: Reset, which is synchronous and active high, clears the sense, both-edges, polarity and mask registers and the raw event vector, so every register read returns 0 and `irq_o` is low.
- R2: A write to 0x404 (sense), 0x408 (both-edges), 0x40C (polarity) or 0x410 (mask) stores bits 7:0 of the write data. A later read of the same offset returns that byte in bits 7:0, with bits 31:8 as 0. Bit n of every vector belongs to pin n.
- R3: A pin whose sense bit is 1 (level) sets its raw bit on every clock edge at which the pin value equals its polarity bit (1 means high, 0 means low).
- R4: A pin whose sense bit is 0 and both-edges bit is 0 sets its raw bit when its present value differs from its previous value and the present value equals the polarity bit (1 means rising, 0 means falling).
- R5: A pin whose sense bit is 0 and both-edges bit is 1 sets its raw bit on any change between its previous and present value.
- R6: Edge detection applies only to pins whose direction bit is 0 (input). A change on a pin with direction bit 1 never sets its raw bit. Level sensing applies whatever the direction.
- R7: A write to 0x41C clears every raw bit whose write-data bit is 1 and leaves the others unchanged. Reads of 0x41C return 0.
- R8: A read of 0x414 returns the raw vector. A read of 0x418 returns raw AND mask. The `stat_raw` and `stat_masked` outputs carry the same two vectors.
- R9: `irq_o` is high exactly when at least one bit of raw AND mask is 1.
- R10: When a set condition and a clear of the same bit fall on the same clock edge, the bit ends up set. A level condition that stays true sets the bit again at the edge that follows a clear.
- R11: Reads of any other offset return 0. Writes to any offset other than the five writable ones, including 0x414 and 0x418, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_cur | input | 8 | Present synchronised pin values |
| pin_prev | input | 8 | Pin values from the previous cycle |
| pin_dir | input | 8 | Pin direction, 1 = output |
| stat_raw | output | 8 | Raw sticky event vector |
| stat_masked | output | 8 | Raw vector AND mask |
| irq_o | output | 1 | Combined interrupt |

## Verification
The checks assume that `pin_prev` really is the one-cycle-old copy of `pin_cur` and that `pin_dir` only moves while pins are steady. An edge is taken to be present for exactly one cycle. The stimulus keeps to this: every table vector first holds `pin_prev` equal to `pin_cur` while the configuration is written and the vector is cleared. It then changes `pin_cur` for exactly one cycle and copies it into `pin_prev` straight afterwards. Writes come at most one per cycle, and the address stays stable across the sampling point.

// File: rtl/gid_pkg.sv
`timescale 1ns/1ps
package gid_pkg;

    localparam int GID_PINS   = 8;
    localparam int GID_ADDR_W = 12;

    localparam logic [GID_ADDR_W-1:0] OFS_SENSE  = 12'h404;
    localparam logic [GID_ADDR_W-1:0] OFS_BOTH   = 12'h408;
    localparam logic [GID_ADDR_W-1:0] OFS_POL    = 12'h40C;
    localparam logic [GID_ADDR_W-1:0] OFS_MASK   = 12'h410;
    localparam logic [GID_ADDR_W-1:0] OFS_RAW    = 12'h414;
    localparam logic [GID_ADDR_W-1:0] OFS_MASKED = 12'h418;
    localparam logic [GID_ADDR_W-1:0] OFS_CLEAR  = 12'h41C;

    typedef logic [GID_PINS-1:0] pinvec_t;

    // Per-pin configuration held in the register bank
    typedef struct packed {
        pinvec_t sense;   // 1 = level, 0 = edge
        pinvec_t both;    // 1 = any edge
        pinvec_t pol;     // 1 = high / rising
        pinvec_t mask;    // 1 = forwarded to irq
    } gid_cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SENSE,
        SEL_BOTH,
        SEL_POL,
        SEL_MASK,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR
    } gid_sel_e;

    function automatic gid_sel_e gid_decode(input logic [GID_ADDR_W-1:0] a);
        gid_sel_e s;
        case (a)
            OFS_SENSE:  s = SEL_SENSE;
            OFS_BOTH:   s = SEL_BOTH;
            OFS_POL:    s = SEL_POL;
            OFS_MASK:   s = SEL_MASK;
            OFS_RAW:    s = SEL_RAW;
            OFS_MASKED: s = SEL_MASKED;
            OFS_CLEAR:  s = SEL_CLEAR;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Trigger decision for a single pin
    function automatic logic gid_pin_fires(
        input logic lvl,
        input logic any_edge,
        input logic pol,
        input logic is_out,
        input logic prev,
        input logic cur
    );
        logic match;
        logic moved;
        match = (cur == pol);
        moved = (cur != prev);
        if (lvl) begin
            return match;
        end
        return !is_out && moved && (any_edge || match);
    endfunction

endpackage

// File: rtl/gid_regs.sv
`timescale 1ns/1ps
module gid_regs
    import gid_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [GID_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [GID_PINS-1:0]   wbyte,
    input  pinvec_t               raw_vec,
    input  pinvec_t               masked_vec,
    output gid_cfg_t              cfg,
    output pinvec_t               clr_vec,
    output logic [DATA_W-1:0]     bus_rdata
);

    localparam int PAD_W = DATA_W - GID_PINS;

    gid_sel_e sel;
    gid_cfg_t cfg_q;
    pinvec_t  rd_byte;

    assign sel = gid_decode(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_SENSE: cfg_q.sense <= wbyte;
                SEL_BOTH:  cfg_q.both  <= wbyte;
                SEL_POL:   cfg_q.pol   <= wbyte;
                SEL_MASK:  cfg_q.mask  <= wbyte;
                default:   ;
            endcase
        end
    end

    always_comb begin
        clr_vec = '0;
        if (bus_wr && (sel == SEL_CLEAR)) begin
            clr_vec = wbyte;
        end
    end

    always_comb begin
        case (sel)
            SEL_SENSE:  rd_byte = cfg_q.sense;
            SEL_BOTH:   rd_byte = cfg_q.both;
            SEL_POL:    rd_byte = cfg_q.pol;
            SEL_MASK:   rd_byte = cfg_q.mask;
            SEL_RAW:    rd_byte = raw_vec;
            SEL_MASKED: rd_byte = masked_vec;
            default:    rd_byte = '0;
        endcase
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rd_byte};
    assign cfg       = cfg_q;

    // R2: a mask write is visible on the next cycle
    a_r2_mask_store: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (sel == SEL_MASK)) |=> (cfg_q.mask == $past(wbyte)));

    // R11: a write to the raw status offset leaves configuration untouched
    a_r11_ro_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (sel == SEL_RAW)) |=> $stable(cfg_q));

endmodule

// File: rtl/gid_detect.sv
`timescale 1ns/1ps
module gid_detect
    import gid_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gid_cfg_t cfg,
    input  pinvec_t  pin_dir,
    input  pinvec_t  pin_prev,
    input  pinvec_t  pin_cur,
    output pinvec_t  set_vec
);

    for (genvar g = 0; g < GID_PINS; g++) begin : g_pin
        assign set_vec[g] = gid_pin_fires(cfg.sense[g], cfg.both[g], cfg.pol[g],
                                          pin_dir[g], pin_prev[g], pin_cur[g]);
    end

    // R6: output pins in edge mode never raise a set request
    a_r6_out_no_edge: assert property (@(posedge clk) disable iff (rst)
        (set_vec & pin_dir & ~cfg.sense) == '0);

    // R4: pins that did not move cannot fire in edge mode
    a_r4_edge_needs_move: assert property (@(posedge clk) disable iff (rst)
        (set_vec & ~cfg.sense & ~(pin_prev ^ pin_cur)) == '0);

endmodule

// File: rtl/gid_status.sv
`timescale 1ns/1ps
module gid_status
    import gid_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t set_vec,
    input  pinvec_t clr_vec,
    input  pinvec_t mask,
    output pinvec_t raw_vec,
    output pinvec_t masked_vec,
    output logic    irq
);

    pinvec_t raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_vec) | set_vec;
        end
    end

    assign raw_vec    = raw_q;
    assign masked_vec = raw_q & mask;
    assign irq        = |masked_vec;

    // R7: a cleared bit with no competing set reads 0 afterwards
    a_r7_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
        (|(clr_vec & ~set_vec)) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));

    // R10: a set request always lands, even against a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gid_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [GID_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [GID_PINS-1:0]   pin_cur,
    input  logic [GID_PINS-1:0]   pin_prev,
    input  logic [GID_PINS-1:0]   pin_dir,
    output logic [GID_PINS-1:0]   stat_raw,
    output logic [GID_PINS-1:0]   stat_masked,
    output logic                  irq_o
);

    gid_cfg_t cfg;
    pinvec_t  set_vec;
    pinvec_t  clr_vec;
    logic     wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:GID_PINS];

    gid_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .wbyte      (bus_wdata[GID_PINS-1:0]),
        .raw_vec    (stat_raw),
        .masked_vec (stat_masked),
        .cfg        (cfg),
        .clr_vec    (clr_vec),
        .bus_rdata  (bus_rdata)
    );

    gid_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .pin_dir  (pin_dir),
        .pin_prev (pin_prev),
        .pin_cur  (pin_cur),
        .set_vec  (set_vec)
    );

    gid_status u_status (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .mask       (cfg.mask),
        .raw_vec    (stat_raw),
        .masked_vec (stat_masked),
        .irq        (irq_o)
    );

    // R9: interrupt line tracks the masked raw vector
    a_r9_irq_any: assert property (@(posedge clk) disable iff (rst)
        irq_o == ((stat_raw & cfg.mask) != '0));

    // R8: masked vector never shows a bit absent from the raw vector
    a_r8_masked_subset: assert property (@(posedge clk) disable iff (rst)
        (stat_masked & ~stat_raw) == '0);

endmodule

// File: tb/test_gpio_irq_detect.sv
`timescale 1ns/1ps
module test_gpio_irq_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_cur = '0;
    logic [7:0]  pin_prev = '0;
    logic [7:0]  pin_dir = '0;
    logic [7:0]  stat_raw;
    logic [7:0]  stat_masked;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_detect i_gpio_irq_detect (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_cur(pin_cur),
        .pin_prev(pin_prev), .pin_dir(pin_dir), .stat_raw(stat_raw),
        .stat_masked(stat_masked), .irq_o(irq_o)
    );

    // {sense, both, pol, dir, prev, cur}
    localparam logic [47:0] VEC [0:9] = '{
        48'h00_00_FF_00_00_0F,
        48'h00_00_00_00_FF_F0,
        48'h00_00_FF_00_FF_F0,
        48'h00_FF_00_00_A5_5A,
        48'h00_00_0F_F0_00_FF,
        48'hFF_00_FF_00_00_00,
        48'hFF_00_0F_00_33_33,
        48'h0F_F0_AA_00_00_FF,
        48'hF0_00_00_FF_0F_00,
        48'h00_55_00_0F_FF_00
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // expected raw vector for one table vector, from R3..R6 and R10
    function automatic logic [7:0] expect_raw(input logic [47:0] v);
        logic [7:0] s, b, p, d, pv, c;
        {s, b, p, d, pv, c} = v;
        return (s & ~(pv ^ p)) | (s & ~(c ^ p)) | (~s & ~d & (pv ^ c) & (b | ~(c ^ p)));
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 raw", {24'd0, stat_raw}, 32'd0);
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        rd(12'h404, r); check("R1 sense", r, 32'd0);
        rd(12'h410, r); check("R1 mask", r, 32'd0);

        // R2: byte storage and readback
        wr(12'h404, 32'hABCD_125A); rd(12'h404, r); check("R2 sense", r, 32'h5A);
        wr(12'h408, 32'hFFFF_FF3C); rd(12'h408, r); check("R2 both", r, 32'h3C);
        wr(12'h40C, 32'h1234_56C3); rd(12'h40C, r); check("R2 pol", r, 32'hC3);
        wr(12'h410, 32'h8000_0081); rd(12'h410, r); check("R2 mask", r, 32'h81);

        // R1: reset again clears the written configuration
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(12'h404, r); check("R1 sense after cfg", r, 32'd0);
        rd(12'h40C, r); check("R1 pol after cfg", r, 32'd0);

        // R3..R6 table walk
        for (int i = 0; i < 10; i++) begin
            logic [7:0] s, b, p, d, pv, c;
            {s, b, p, d, pv, c} = VEC[i];
            @(negedge clk);
            pin_dir = d; pin_prev = pv; pin_cur = pv;
            wr(12'h404, 32'h0);
            wr(12'h40C, {24'd0, p});
            wr(12'h408, {24'd0, b});
            wr(12'h404, {24'd0, s});
            wr(12'h41C, 32'hFF);
            pin_cur = c;
            @(negedge clk);
            check($sformatf("R3-6 vec%0d raw R3 R4 R5 R6", i), {24'd0, stat_raw}, {24'd0, expect_raw(VEC[i])});
            rd(12'h414, r);
            check($sformatf("R8 vec%0d raw read", i), r, {24'd0, expect_raw(VEC[i])});
            pin_prev = pin_cur;
        end

        // R7: partial clear; all pins edge both, every pin toggles
        wr(12'h404, 32'h0); wr(12'h408, 32'hFF);
        @(negedge clk);
        pin_dir = 8'h00; pin_prev = 8'h00; pin_cur = 8'h00;
        wr(12'h41C, 32'hFF);
        pin_cur = 8'hFF;
        @(negedge clk);
        pin_prev = 8'hFF;
        check("R5 all toggle", {24'd0, stat_raw}, 32'hFF);
        wr(12'h41C, 32'h0F);
        check("R7 partial clear", {24'd0, stat_raw}, 32'hF0);
        rd(12'h41C, r); check("R7 clear reads 0", r, 32'd0);

        // R11: unmapped and read-only offsets
        rd(12'h400, r); check("R11 read 0x400", r, 32'd0);
        rd(12'h420, r); check("R11 read 0x420", r, 32'd0);
        wr(12'h414, 32'h0F); check("R11 write raw", {24'd0, stat_raw}, 32'hF0);
        wr(12'h418, 32'hFF); check("R11 write masked", {24'd0, stat_raw}, 32'hF0);
        wr(12'h420, 32'hFF); rd(12'h410, r); check("R11 write 0x420 mask", r, 32'd0);

        // R8 / R9: mask behaviour
        check("R9 irq masked off", {31'd0, irq_o}, 32'd0);
        wr(12'h410, 32'h30);
        rd(12'h418, r); check("R8 masked read", r, 32'h30);
        check("R8 masked port", {24'd0, stat_masked}, 32'h30);
        check("R9 irq on", {31'd0, irq_o}, 32'd1);
        wr(12'h410, 32'h0F);
        check("R9 irq off", {31'd0, irq_o}, 32'd0);
        wr(12'h41C, 32'hFF);
        check("R7 clear all", {24'd0, stat_raw}, 32'd0);

        // R10: active level re-asserts after clear
        wr(12'h408, 32'h0);
        wr(12'h40C, 32'h01);
        pin_prev = 8'h01; pin_cur = 8'h01;
        wr(12'h404, 32'h01);
        wr(12'h41C, 32'h01);
        check("R10 level stays set", {24'd0, stat_raw}, 32'h01);
        @(negedge clk);
        pin_prev = 8'h00; pin_cur = 8'h00;
        wr(12'h41C, 32'h01);
        check("R3 inactive level clears", {24'd0, stat_raw}, 32'h00);

        // R10: edge and clear on the same edge; pin 1 rising
        wr(12'h40C, 32'h02);
        wr(12'h404, 32'h00);
        wr(12'h41C, 32'hFF);
        @(negedge clk);
        bus_addr = 12'h41C; bus_wdata = 32'h02; bus_wr = 1'b1;
        pin_cur = 8'h02;
        @(negedge clk);
        bus_wr = 1'b0; pin_prev = 8'h02;
        check("R10 edge beats clear", {24'd0, stat_raw}, 32'h02);
        @(negedge clk);
        check("R4 no repeat without move", {24'd0, stat_raw}, 32'h02);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule